// File: doc/BRIEF.md
# ISA DMA Channel Request Agent

This block sits on the card side of one ISA DMA channel. When local logic signals that its buffer needs service, the agent raises a DMA request. It keeps that request up until the system controller acknowledges it. During acknowledged bus cycles it exchanges one data item per I/O strobe. No address decode is involved: the active-low acknowledge together with the address-enable line selects the card. A terminal-count pulse seen during an acknowledged strobe closes the block transfer and produces a one-clock completion flag toward local logic.

The agent works in single-transfer fashion. After each acknowledged strobe completes, the request drops. If the block has not yet ended, the request is raised again once the acknowledge is released. The channel number is a parameter, and it fixes the data width. All bus inputs are assumed to be already synchronised to the local clock.

Top module: `isa_dma_agent`

## Requirements
- R1: After reset the request, completion flag, receive strobe, transmit-taken strobe and bus output enable are all low.
- R2: A rising edge on the need input while the agent is idle raises the request on the next clock.
- R3: Once raised, the request stays high until the acknowledge (active low) is seen.
- R4: When the write strobe (active low) is released while the acknowledge is low and address-enable is high, the agent copies the low channel-width bits of the data bus into the receive data output. The receive strobe pulses for exactly one clock.
- R5: While the read strobe (active low) is low with the acknowledge low and address-enable high, the bus output enable is high and the bus data output equals the local transmit data. The transmit-taken strobe pulses for one clock after the read strobe is released.
- R6: Strobes seen while the acknowledge is high, or while address-enable is low, cause no receive strobe, no transmit-taken strobe and no output enable, and they do not count as a transfer.
- R7: After an acknowledged strobe completes, the request is low. If no terminal count was seen, the request rises again one clock after the acknowledge is released.
- R8: A terminal count seen during an acknowledged strobe ends the block. One clock after the acknowledge is released, the completion flag is high for exactly one clock while the request stays low, and the agent then returns to idle.
- R9: Channels 0 to 3 give an 8-bit data path and channels 5 to 7 give a 16-bit data path. Channel 4, or any channel outside 0 to 7, stops elaboration.
- R10: If the need input is held high after completion, no new request is raised. A new block starts only on a new rising edge of the need input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| need_i | input | 1 | Local request for a block transfer (edge-started) |
| tx_data_i | input | DW | Local data offered on read-from-device cycles |
| rx_data_o | output | DW | Data captured on write-to-device cycles |
| rx_valid_o | output | 1 | One-clock strobe: rx_data_o updated |
| tx_taken_o | output | 1 | One-clock strobe: tx_data_i was consumed |
| done_o | output | 1 | One-clock block completion flag |
| drq_o | output | 1 | DMA request, active high |
| dack_ni | input | 1 | DMA acknowledge, active low |
| aen_i | input | 1 | Address enable, high while DMA owns the bus |
| iord_ni | input | 1 | I/O read strobe, active low |
| iowr_ni | input | 1 | I/O write strobe, active low |
| tc_i | input | 1 | Terminal count pulse |
| bus_d_i | input | DW | Data bus input |
| bus_d_o | output | DW | Data bus output value |
| bus_d_oe_o | output | 1 | Data bus output enable |

## Verification
A state machine stuck in the wrong state shows up on drq_o within one clock of an acknowledge edge. Examples are a request that drops before the acknowledge, a request that fails to return after the acknowledge is released, or one that returns after a terminal count. A lost terminal-count record or a mis-set transfer record shows on done_o or drq_o one clock after the acknowledge is released. A wrong strobe-edge history shows on rx_valid_o, tx_taken_o or bus_d_oe_o in the clock that follows the strobe release. Data and width faults appear on rx_data_o and bus_d_o in those same cycles.

// File: rtl/isa_dma_pkg.sv
package isa_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } dma_state_e;

  function automatic int chan_width(input int chan);
    return (chan >= 5) ? 16 : 8;
  endfunction

endpackage

// File: rtl/isa_dma_datapath.sv
module isa_dma_datapath #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dack_ni,
  input  logic          aen_i,
  input  logic          iord_ni,
  input  logic          iowr_ni,
  input  logic          tc_i,
  input  logic [DW-1:0] bus_d_i,
  input  logic [DW-1:0] tx_data_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          tx_taken_o,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o,
  output logic          xfer_end_o,
  output logic          tc_hit_o
);

  logic qual, iord_q, iowr_q, wr_end, rd_end;

  assign qual   = !dack_ni && aen_i;
  assign wr_end = qual && !iowr_q && iowr_ni;
  assign rd_end = qual && !iord_q && iord_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iord_q     <= 1'b1;
      iowr_q     <= 1'b1;
      rx_valid_o <= 1'b0;
      tx_taken_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      iord_q     <= iord_ni;
      iowr_q     <= iowr_ni;
      rx_valid_o <= wr_end;
      tx_taken_o <= rd_end;
      if (wr_end) rx_data_o <= bus_d_i;
    end
  end

  assign bus_d_o    = tx_data_i;
  assign bus_d_oe_o = qual && !iord_ni;
  assign xfer_end_o = wr_end || rd_end;
  assign tc_hit_o   = qual && tc_i && (!iord_ni || !iowr_ni);

  // R4
  rx_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(!dack_ni) && $past(aen_i)));
  // R4
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R5
  tx_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_taken_o |-> ($past(!dack_ni) && $past(aen_i)));

endmodule

// File: rtl/isa_dma_fsm.sv
module isa_dma_fsm
  import isa_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_i,
  input  logic dack_ni,
  input  logic xfer_end_i,
  input  logic tc_hit_i,
  output logic drq_o,
  output logic done_o
);

  dma_state_e state_q, state_d;
  logic need_q, need_rise, xfer_done_q, tc_seen_q;

  assign need_rise = need_i && !need_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (need_rise) state_d = ST_REQ;
      ST_REQ:  if (!dack_ni) state_d = ST_XFER;
      ST_XFER: if (dack_ni) state_d = (tc_seen_q || tc_hit_i) ? ST_DONE : ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      need_q      <= 1'b0;
      xfer_done_q <= 1'b0;
      tc_seen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      need_q  <= need_i;
      if (state_q != ST_XFER) begin
        xfer_done_q <= 1'b0;
        tc_seen_q   <= 1'b0;
      end else begin
        if (xfer_end_i) xfer_done_q <= 1'b1;
        if (tc_hit_i)   tc_seen_q   <= 1'b1;
      end
    end
  end

  // single transfer: request falls once the acknowledged strobe completes
  assign drq_o  = (state_q == ST_REQ) || (state_q == ST_XFER && !xfer_done_q);
  assign done_o = (state_q == ST_DONE);

  // R3
  drq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && dack_ni && state_q == ST_REQ) |=> drq_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_no_drq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !drq_o);
  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_o) |-> ($past(state_q) != ST_XFER || $past(dack_ni)));

endmodule

// File: rtl/isa_dma_agent.sv
module isa_dma_agent #(
  parameter  int CHAN = 1,
  localparam int DW   = isa_dma_pkg::chan_width(CHAN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          need_i,
  input  logic [DW-1:0] tx_data_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          tx_taken_o,
  output logic          done_o,
  output logic          drq_o,
  input  logic          dack_ni,
  input  logic          aen_i,
  input  logic          iord_ni,
  input  logic          iowr_ni,
  input  logic          tc_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o
);

  // R9
  if (CHAN == 4 || CHAN < 0 || CHAN > 7) begin : g_bad_chan
    $error("isa_dma_agent: channel %0d is not available to cards", CHAN);
  end

  logic xfer_end, tc_hit;

  isa_dma_datapath #(.DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dack_ni    (dack_ni),
    .aen_i      (aen_i),
    .iord_ni    (iord_ni),
    .iowr_ni    (iowr_ni),
    .tc_i       (tc_i),
    .bus_d_i    (bus_d_i),
    .tx_data_i  (tx_data_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .tx_taken_o (tx_taken_o),
    .bus_d_o    (bus_d_o),
    .bus_d_oe_o (bus_d_oe_o),
    .xfer_end_o (xfer_end),
    .tc_hit_o   (tc_hit)
  );

  isa_dma_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .need_i     (need_i),
    .dack_ni    (dack_ni),
    .xfer_end_i (xfer_end),
    .tc_hit_i   (tc_hit),
    .drq_o      (drq_o),
    .done_o     (done_o)
  );

endmodule

// File: tb/tb_isa_dma_agent.sv
module tb_isa_dma_agent;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        need, dack_n, aen, iord_n, iowr_n, tc;
  logic [15:0] bus_d;
  logic [7:0]  tx8;
  logic [15:0] tx16;
  logic [7:0]  rx8, bo8;
  logic [15:0] rx16, bo16;
  logic        rxv, txt, done, drq, oe;
  logic        rxv_w, txt_w, done_w, drq_w, oe_w;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  isa_dma_agent #(.CHAN(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .need_i(need), .tx_data_i(tx8),
    .rx_data_o(rx8), .rx_valid_o(rxv), .tx_taken_o(txt), .done_o(done),
    .drq_o(drq), .dack_ni(dack_n), .aen_i(aen), .iord_ni(iord_n),
    .iowr_ni(iowr_n), .tc_i(tc), .bus_d_i(bus_d[7:0]), .bus_d_o(bo8),
    .bus_d_oe_o(oe));

  isa_dma_agent #(.CHAN(5)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .need_i(need), .tx_data_i(tx16),
    .rx_data_o(rx16), .rx_valid_o(rxv_w), .tx_taken_o(txt_w), .done_o(done_w),
    .drq_o(drq_w), .dack_ni(dack_n), .aen_i(aen), .iord_ni(iord_n),
    .iowr_ni(iowr_n), .tc_i(tc), .bus_d_i(bus_d), .bus_d_o(bo16),
    .bus_d_oe_o(oe_w));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    need = 0; dack_n = 1; aen = 0; iord_n = 1; iowr_n = 1; tc = 0;
    bus_d = '0; tx8 = '0; tx16 = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!drq && !done && !rxv && !txt && !oe, "R1 reset outputs",
        {drq, done, rxv, txt, oe}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_start();
    need = 1;
    @(negedge clk);
    chk(drq == 1, "R2 request after need edge", drq, 1);
  endtask

  task automatic t_cycle(input bit wr, input logic [15:0] d, input bit end_blk);
    int dly = $urandom_range(1, 4);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(drq == 1, "R3 request held before ack", drq, 1);
    end
    dack_n = 0; aen = 1;
    @(negedge clk);
    bus_d = d; tx8 = d[7:0]; tx16 = d; tc = end_blk;
    if (wr) iowr_n = 0; else iord_n = 0;
    @(negedge clk);
    if (!wr) begin
      chk(oe == 1 && bo8 == d[7:0], "R5 read drive", {oe, bo8}, {1'b1, d[7:0]});
      chk(oe_w == 1 && bo16 == d, "R9 16-bit read drive", bo16, d);
    end
    iowr_n = 1; iord_n = 1; tc = 0;
    @(negedge clk);
    if (wr) begin
      chk(rxv == 1 && rx8 == d[7:0], "R4 write capture", {rxv, rx8}, {1'b1, d[7:0]});
      chk(rxv_w == 1 && rx16 == d, "R9 16-bit write capture", rx16, d);
    end else begin
      chk(txt == 1, "R5 transmit taken", txt, 1);
    end
    chk(drq == 0, "R7 request low after transfer", drq, 0);
    @(negedge clk);
    chk(!rxv && !txt, "R4 strobe one clock", {rxv, txt}, 0);
    dack_n = 1; aen = 0;
    @(negedge clk);
    if (end_blk) begin
      chk(done == 1 && drq == 0, "R8 done pulse", {done, drq}, 2'b10);
      @(negedge clk);
      chk(done == 0 && drq == 0, "R8 done single clock", {done, drq}, 0);
    end else begin
      chk(drq == 1, "R7 request re-raised", drq, 1);
    end
  endtask

  task automatic t_norestart();
    repeat (5) @(negedge clk);
    chk(drq == 0, "R10 held need does not restart", drq, 0);
    need = 0;
    @(negedge clk);
    need = 1;
    @(negedge clk);
    chk(drq == 1, "R10 new edge restarts", drq, 1);
  endtask

  task automatic t_ignored();
    bit seen = 0;
    aen = 1; dack_n = 1;
    iowr_n = 0; iord_n = 0;
    @(negedge clk);
    chk(oe == 0, "R6 no drive without ack", oe, 0);
    iowr_n = 1; iord_n = 1;
    repeat (2) begin
      @(negedge clk);
      seen |= rxv | txt;
    end
    chk(!seen && drq == 1, "R6 no transfer without ack", {seen, drq}, 2'b01);
    aen = 0; dack_n = 0;
    @(negedge clk);
    iowr_n = 0; iord_n = 0;
    @(negedge clk);
    chk(oe == 0, "R6 no drive with aen low", oe, 0);
    iowr_n = 1; iord_n = 1;
    seen = 0;
    repeat (2) begin
      @(negedge clk);
      seen |= rxv | txt;
    end
    chk(!seen && drq == 1, "R6 no transfer with aen low", {seen, drq}, 2'b01);
    dack_n = 1;
    @(negedge clk);
    chk(drq == 1, "R6 request still pending", drq, 1);
  endtask

  initial begin
    t_reset();
    t_start();
    t_cycle(1'b1, 16'hA53C, 1'b0);
    t_cycle(1'b0, 16'h5AC3, 1'b0);
    t_cycle(1'b1, 16'h0FF0, 1'b1);
    t_norestart();
    t_ignored();
    t_cycle(1'b0, 16'hBEEF, 1'b0);
    t_cycle(1'b1, 16'h1281, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule